// File: doc/BRIEF.md
# Tick Counter with One-Shot Compare Interrupt

This block holds a free-running tick count and a compare limit. Each clock cycle in which `tick_en` is high moves the count forward by one. The count wraps inside the lower 63 bits. The top bit of every written word is not count data. It is a shared disable flag: writing it sets or clears the flag, and a read returns it in the top bit.

Software loads the count and the limit through one write port, with a select line. When a tick moves the count onto the armed limit, the block emits a one-cycle wake pulse and sets a sticky soft-interrupt bit. That bit stays high until an external clear input removes it. Each limit write arms the compare for one event only. If the limit written is not ahead of the current count, the event fires on the next tick instead of waiting for the count to wrap.

The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset, the count is zero, the disable flag is set, the compare is disarmed, and both `soft_bit` and `match_pulse` are low. A count read therefore returns 0x8000000000000000.
- R2: A write with `wr_sel`=0 loads `wr_data[62:0]` into the count and `wr_data[63]` into the disable flag. In the same cycle the write takes priority over a tick.
- R3: Each clock cycle in which `tick_en` is high and no write occurs increments the count by one.
- R4: `rd_data` is combinational. With `rd_sel`=0 it gives the count in bits 62:0, and with `rd_sel`=1 it gives the limit. In both cases bit 63 carries the disable flag.
- R5: A tick at count 0x7FFFFFFFFFFFFFFF brings the count to zero.
- R6: When a tick moves the count to equal an armed limit while the block is enabled, `match_pulse` and `soft_bit` both rise after that same clock edge.
- R7: `match_pulse` lasts exactly one cycle. After it fires, the compare stays disarmed until the next limit write.
- R8: `soft_bit` stays high until a cycle with `soft_clr` high. If a new match arrives in that same cycle, the set wins over the clear.
- R9: A write with `wr_sel`=1 loads `wr_data[62:0]` as the limit and `wr_data[63]` into the disable flag.
- R10: A limit value of zero arms nothing, so no match follows from it.
- R11: While the disable flag is set, no match occurs. A limit written with bit 63 set leaves the compare disarmed.
- R12: A nonzero, enabled limit written at or below the current count fires on the next tick cycle. Cycles without a tick do not fire it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance the count this cycle |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 limit |
| wr_data | input | 64 | Write word; bit 63 is the disable flag |
| rd_sel | input | 1 | Read source: 0 count, 1 limit |
| rd_data | output | 64 | Selected value with the disable flag in bit 63 |
| soft_clr | input | 1 | Clear the sticky soft-interrupt bit |
| match_pulse | output | 1 | One-cycle wake pulse on a match |
| soft_bit | output | 1 | Sticky soft-interrupt bit |

## Verification
The compare is tried with several limit patterns, and each pattern separates one piece of behaviour:
- A limit ahead of the count checks the exact cycle of the match.
- A limit behind the count, first with idle cycles and then with a tick, shows that a late event waits for a tick and does not wait for a wrap.
- A zero limit placed below the count separates "unarmed" from "late".
- Disabled limits, and a disable applied after arming, show that the flag suppresses the match and is not merely reported on read.
- Re-crossing the old limit after a match shows the compare is one-shot.
- Count writes near the 63-bit maximum, and a write made together with a tick, cover the wrap and the write priority.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_LIMIT = 1'b1
  } tick_sel_e;
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tick_count_core.sv
module tick_count_core #(
  parameter int TICK_W = 64,
  localparam int CNT_W = TICK_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_wr,
  input  logic             ctl_wr,
  input  logic [TICK_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dis_q
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [CNT_W-1:0] MAX_C = '1;

  logic [CNT_W-1:0] cnt_d;
  logic             dis_d;

  // Next state: a count write beats a tick; any write updates the flag.
  always_comb begin
    cnt_d = cnt_q;
    dis_d = dis_q;
    if (cnt_wr)       cnt_d = wr_data[CNT_W-1:0];
    else if (tick_en) cnt_d = cnt_q + ONE_C;
    if (ctl_wr)       dis_d = wr_data[CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dis_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      dis_q <= dis_d;
    end
  end

  a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr && cnt_q != MAX_C) |=> cnt_q == $past(cnt_q) + ONE_C);

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr && cnt_q == MAX_C) |=> cnt_q == '0);

  a_r2_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_data[CNT_W-1:0]) && dis_q == $past(wr_data[CNT_W])));
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int TICK_W = 64,
  localparam int CNT_W = TICK_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_wr,
  input  logic             lim_wr,
  input  logic [TICK_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             dis_q,
  output logic [CNT_W-1:0] lim_q,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] lim_d;
  logic             armed_q, armed_d;
  logic             late_q, late_d;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] wr_val;
  logic             wr_ctl;
  logic             hit;

  assign wr_val  = wr_data[CNT_W-1:0];
  assign wr_ctl  = wr_data[CNT_W];
  assign cnt_inc = cnt_q + ONE_C;
  assign hit     = late_q || (cnt_inc == lim_q);

  // A match needs a plain tick cycle (no write), an armed enabled compare,
  // and either a pending late event or the count landing on the limit.
  assign fire = tick_en && !cnt_wr && !lim_wr && armed_q && !dis_q && hit;

  always_comb begin
    lim_d   = lim_q;
    armed_d = armed_q;
    late_d  = late_q;
    if (lim_wr) begin
      lim_d   = wr_val;
      armed_d = (wr_val != '0) && !wr_ctl;
      late_d  = (wr_val != '0) && !wr_ctl && (wr_val <= cnt_q);
    end else if (cnt_wr) begin
      late_d  = armed_q && (lim_q <= wr_val);
    end else if (fire) begin
      armed_d = 1'b0;
      late_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= '0;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      lim_q   <= lim_d;
      armed_q <= armed_d;
      late_q  <= late_d;
    end
  end

  a_r9_limit_load: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr |=> lim_q == $past(wr_val));

  a_r10_zero_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && wr_val == '0) |=> !armed_q);

  a_r11_masked_limit_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && wr_ctl) |=> !armed_q);

  a_r7_disarm_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q);
endmodule

// File: rtl/tick_softint.sv
module tick_softint (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic soft_clr,
  output logic match_pulse,
  output logic soft_bit
);
  logic pulse_d, soft_d;

  // Set has priority over clear.
  always_comb begin
    pulse_d = fire;
    soft_d  = fire || (soft_bit && !soft_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_pulse <= 1'b0;
      soft_bit    <= 1'b0;
    end else begin
      match_pulse <= pulse_d;
      soft_bit    <= soft_d;
    end
  end

  a_r6_pulse_sets_soft: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> soft_bit);

  a_r8_soft_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_bit && !soft_clr) |=> soft_bit);
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
  parameter int TICK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [TICK_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [TICK_W-1:0] rd_data,
  input  logic              soft_clr,
  output logic              match_pulse,
  output logic              soft_bit
);
  import tick_timer_pkg::*;
  localparam int CNT_W = TICK_W - 1;

  logic             rst_sync_n;
  logic             cnt_wr, lim_wr;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             dis_q;
  logic             fire;

  assign cnt_wr = wr_en && (tick_sel_e'(wr_sel) == SEL_COUNT);
  assign lim_wr = wr_en && (tick_sel_e'(wr_sel) == SEL_LIMIT);

  tick_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  tick_count_core #(.TICK_W(TICK_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .tick_en(tick_en),
    .cnt_wr(cnt_wr), .ctl_wr(wr_en), .wr_data(wr_data),
    .cnt_q(cnt_q), .dis_q(dis_q));

  tick_compare #(.TICK_W(TICK_W)) u_cmp (
    .clk(clk), .rst_n(rst_sync_n), .tick_en(tick_en),
    .cnt_wr(cnt_wr), .lim_wr(lim_wr), .wr_data(wr_data),
    .cnt_q(cnt_q), .dis_q(dis_q), .lim_q(lim_q), .fire(fire));

  tick_softint u_soft (
    .clk(clk), .rst_n(rst_sync_n), .fire(fire), .soft_clr(soft_clr),
    .match_pulse(match_pulse), .soft_bit(soft_bit));

  always_comb begin
    if (tick_sel_e'(rd_sel) == SEL_LIMIT) rd_data = {dis_q, lim_q};
    else                                  rd_data = {dis_q, cnt_q};
  end

  a_r11_no_match_when_disabled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_pulse |-> !$past(dis_q));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_pulse |=> !match_pulse);
endmodule

// File: tb/tick_compare_timer_test.sv
module tick_compare_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, wr_en, wr_sel, rd_sel, soft_clr;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic        match_pulse, soft_bit;

  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

  typedef struct {
    int          kind;   // 0 rd_data, 1 match_pulse, 2 soft_bit
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  mon_ev;
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;

  always #10 clk = ~clk;

  tick_compare_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .soft_clr(soft_clr), .match_pulse(match_pulse), .soft_bit(soft_bit));

  // Monitor: pops expected items and compares against the ports.
  always begin
    @(mon_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = rd_data;
        1:       act = {63'd0, match_pulse};
        default: act = {63'd0, soft_bit};
      endcase
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [63:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    -> mon_ev;
    #1;
  endtask

  task automatic rd_chk(input logic sel, input logic [63:0] exp, input string tag);
    rd_sel = sel;
    #1;
    expect_item(0, exp, tag);
  endtask

  task automatic wr(input logic sel, input logic [63:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic clear_soft();
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_sel = 1'b0;
    wr_data = '0; rd_sel = 1'b0; soft_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(0, DIS, "R1 count after reset");
    rd_chk(1, DIS, "R1 limit after reset");
    expect_item(2, 64'd0, "R1 soft after reset");
    expect_item(1, 64'd0, "R1 pulse after reset");

    // R2 / R3 load and increment
    wr(0, 64'h10);
    rd_chk(0, 64'h10, "R2 count load");
    step(5);
    rd_chk(0, 64'h15, "R3 five ticks");
    tick_en = 1'b1;
    wr(0, 64'h40);
    tick_en = 1'b0;
    rd_chk(0, 64'h40, "R2 write beats tick");

    // R4 disabled flag on read
    wr(0, DIS | 64'h100);
    step(3);
    rd_chk(0, DIS | 64'h103, "R4 read with flag");

    // R5 wrap
    wr(0, 64'h7FFF_FFFF_FFFF_FFFF);
    step(1);
    rd_chk(0, 64'h0, "R5 wrap to zero");

    // R6 / R7 / R8 match
    wr(0, 64'h0);
    wr(1, 64'h5);
    rd_chk(1, 64'h5, "R9 limit readback");
    step(4);
    expect_item(2, 64'd0, "R6 no match before limit");
    step(1);
    expect_item(1, 64'd1, "R6 pulse on match");
    expect_item(2, 64'd1, "R6 soft on match");
    @(negedge clk);
    expect_item(1, 64'd0, "R7 pulse one cycle");
    expect_item(2, 64'd1, "R8 soft sticky");
    clear_soft();
    expect_item(2, 64'd0, "R8 soft cleared");
    wr(0, 64'h0);
    step(7);
    expect_item(2, 64'd0, "R7 one-shot no refire");

    // R10 zero limit below count
    wr(0, 64'h3);
    wr(1, 64'h0);
    step(3);
    expect_item(2, 64'd0, "R10 zero limit");

    // R11 disabled limit, then disable after arming
    wr(0, 64'h0);
    wr(1, DIS | 64'h4);
    rd_chk(1, DIS | 64'h4, "R9 limit with flag");
    step(6);
    expect_item(2, 64'd0, "R11 masked limit");
    rd_chk(0, DIS | 64'h6, "R4 count shows flag");
    wr(0, 64'h0);
    wr(1, 64'h8);
    wr(0, DIS | 64'h2);
    step(10);
    expect_item(2, 64'd0, "R11 disabled after arm");

    // R12 late limit
    wr(0, 64'd20);
    wr(1, 64'd10);
    repeat (3) @(negedge clk);
    expect_item(2, 64'd0, "R12 idle does not fire");
    step(1);
    expect_item(1, 64'd1, "R12 late pulse on tick");
    expect_item(2, 64'd1, "R12 late soft");
    clear_soft();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule